// File: doc/BRIEF.md
# Translation Unit Mode and Register Controller

This block owns the software-visible control and status registers of a small address-translation unit and steers the unit between its operating modes. A 32-bit register port writes and reads the page-directory base, a status word, a write-only command register, the captured fault address, the interrupt status/clear/mask group and a single-line invalidate register. From these the block drives paging-enable, stall and cache-flush controls toward the translation datapath. In the other direction it takes page-fault and bus-error events from that datapath.

Software issues a three-bit command code to enable or disable paging, enter or leave stall, flush the whole translation cache, acknowledge a fault or hard-reset the controller. A stall request waits until no translations are in flight. It is refused while a page fault is pending. A fault holds its captured address and attributes until software acknowledges it. Reads are combinational from the current register state. All register effects appear one clock after the write.

Top module: `xlat_mode_ctrl`

## Requirements
- R1: A write to the directory base (offset 0x00) stores only bits [31:12]; a read returns those bits with bits [11:0] as zero (0xCAFEBABE reads back as 0xCAFEB000), and the same value drives `dirBase`.
- R2: Command code 0 (written to offset 0x08, code in bits [2:0]) sets `pagingOn` and status bit 0 one cycle after the write; code 1 clears both one cycle after the write.
- R3: Command code 2 requests stall; `stallOn` and status bit 2 rise at the first clock edge where `xlatBusy` is low, so with `xlatBusy` low they rise one cycle after the write. Status bit 31 is the inverse of status bit 2. Status bit 3 (idle) is the inverse of `xlatBusy`. Status bit 4 follows `replayEmpty`.
- R4: While a page fault is active (status bit 1), a stall request is dropped: `stallOn` stays low, and it stays low after the fault is acknowledged.
- R5: Command code 3 clears `stallOn` and any pending stall request one cycle after the write.
- R6: Command code 4 produces `flushPulse` high for exactly the one cycle after the write.
- R7: A write to offset 0x10 produces `invPulse` high for exactly the one cycle after the write, with `invAddr` equal to the written data.
- R8: A `faultEvt` while no fault is active sets status bit 1 and raw interrupt bit 0. It also captures `faultVa` into the fault address register (offset 0x0C), `faultIsWrite` into status bit 5 and `faultBusId` into status bits [10:6]. Later faults do not overwrite this capture, and the fault stays active until command code 5 is written.
- R9: Raw interrupt status (offset 0x14) has page fault in bit 0 and bus error (`busErrEvt`) in bit 1. Writing ones to offset 0x18 clears the matching raw bits, and a new event in the same cycle wins over the clear. The mask register is offset 0x1C. Masked status (offset 0x20) is raw AND mask, and `irq` is the OR of the masked bits.
- R10: Command code 6 returns every register and output to its power-on value one cycle after the write: base 0, paging, stall and fault off, raw status and mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Byte offset for reads and writes |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| xlatBusy | input | 1 | Translations are in flight in the datapath |
| replayEmpty | input | 1 | Datapath replay buffer is empty |
| faultEvt | input | 1 | Page-fault event pulse |
| faultVa | input | 32 | Virtual address of the faulting access |
| faultIsWrite | input | 1 | Faulting access was a write |
| faultBusId | input | 5 | Requester id of the faulting access |
| busErrEvt | input | 1 | Read bus-error event pulse |
| pagingOn | output | 1 | Translation enabled |
| stallOn | output | 1 | Datapath held in stall |
| flushPulse | output | 1 | One-cycle whole-cache flush |
| invPulse | output | 1 | One-cycle single-line invalidate |
| invAddr | output | 32 | Address for the single-line invalidate |
| dirBase | output | 32 | Page-directory base |
| irq | output | 1 | Interrupt request, OR of masked status |

## Verification
The checker watches four things on every cycle: a stall is never granted with a fault pending or translations in flight, a pending fault is held until an acknowledge or hard reset, every flush or invalidate pulse traces back to the matching write one cycle earlier, and paging comes on after its command. Some behaviours only the bench scenarios show. These are the delayed stall grant once the datapath drains, the refusal leaving no stall behind after the acknowledge, and the first-fault capture surviving a second fault. The bench also covers the truncated base readback, clear-versus-event priority under random traffic, and the complete return to power-on state after a hard reset.

// File: rtl/xlat_ctl_pkg.sv
package xlat_ctl_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_BASE  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CMD   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_FADDR = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_INV   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_MSTAT = 8'h20;

  localparam logic [2:0] OP_PAGE_ON   = 3'd0;
  localparam logic [2:0] OP_PAGE_OFF  = 3'd1;
  localparam logic [2:0] OP_STALL_IN  = 3'd2;
  localparam logic [2:0] OP_STALL_OUT = 3'd3;
  localparam logic [2:0] OP_FLUSH     = 3'd4;
  localparam logic [2:0] OP_FAULT_ACK = 3'd5;
  localparam logic [2:0] OP_HARD_RST  = 3'd6;

  // strobes from the command decoder to the register bank
  typedef struct packed {
    logic pageOn;
    logic pageOff;
    logic flush;
    logic faultAck;
    logic hardRst;
    logic baseWr;
    logic invWr;
    logic clrWr;
    logic maskWr;
  } ctl_strobe_t;
endpackage

// File: rtl/xlat_cmd_ctrl.sv
module xlat_cmd_ctrl
  import xlat_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [2:0]        cmdCode,
  input  logic              faultActive,
  input  logic              xlatBusy,
  output ctl_strobe_t       strobe,
  output logic              stallOn
);
  logic cmdWr, stallReq, stallLeave, stallPend;

  always_comb begin
    cmdWr           = regWe && (regAddr == OFS_CMD);
    stallReq        = cmdWr && (cmdCode == OP_STALL_IN);
    stallLeave      = cmdWr && (cmdCode == OP_STALL_OUT);
    strobe.pageOn   = cmdWr && (cmdCode == OP_PAGE_ON);
    strobe.pageOff  = cmdWr && (cmdCode == OP_PAGE_OFF);
    strobe.flush    = cmdWr && (cmdCode == OP_FLUSH);
    strobe.faultAck = cmdWr && (cmdCode == OP_FAULT_ACK);
    strobe.hardRst  = cmdWr && (cmdCode == OP_HARD_RST);
    strobe.baseWr   = regWe && (regAddr == OFS_BASE);
    strobe.invWr    = regWe && (regAddr == OFS_INV);
    strobe.clrWr    = regWe && (regAddr == OFS_CLR);
    strobe.maskWr   = regWe && (regAddr == OFS_MASK);
  end

  // stall sequencing: wait for drain, drop the request on a fault
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallOn   <= 1'b0;
      stallPend <= 1'b0;
    end else if (strobe.hardRst || stallLeave) begin
      stallOn   <= 1'b0;
      stallPend <= 1'b0;
    end else if (faultActive) begin
      stallPend <= 1'b0;
    end else if (stallReq || stallPend) begin
      if (!xlatBusy) begin
        stallOn   <= 1'b1;
        stallPend <= 1'b0;
      end else begin
        stallPend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/xlat_reg_bank.sv
module xlat_reg_bank
  import xlat_ctl_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int BUSID_W    = 5,
  parameter int NUM_IRQ    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_strobe_t        strobe,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic               faultEvt,
  input  logic [DATA_W-1:0]  faultVa,
  input  logic               faultIsWrite,
  input  logic [BUSID_W-1:0] faultBusId,
  input  logic               busErrEvt,
  output logic [DATA_W-1:0]  baseQ,
  output logic               pagingQ,
  output logic               faultQ,
  output logic [DATA_W-1:0]  faultAddrQ,
  output logic               faultWrQ,
  output logic [BUSID_W-1:0] busIdQ,
  output logic [NUM_IRQ-1:0] rawQ,
  output logic [NUM_IRQ-1:0] maskQ,
  output logic               flushQ,
  output logic               invQ,
  output logic [DATA_W-1:0]  invAddrQ
);
  localparam int BASE_W = DATA_W - PAGE_SHIFT;

  logic [NUM_IRQ-1:0] evtVec, clrVec;

  always_comb begin
    evtVec    = '0;
    evtVec[0] = faultEvt;
    evtVec[1] = busErrEvt;
    clrVec    = strobe.clrWr ? regWdata[NUM_IRQ-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.hardRst) begin
      baseQ      <= '0;
      pagingQ    <= 1'b0;
      faultQ     <= 1'b0;
      faultAddrQ <= '0;
      faultWrQ   <= 1'b0;
      busIdQ     <= '0;
      rawQ       <= '0;
      maskQ      <= '0;
      flushQ     <= 1'b0;
      invQ       <= 1'b0;
      invAddrQ   <= '0;
    end else begin
      flushQ <= strobe.flush;
      invQ   <= strobe.invWr;
      if (strobe.invWr)  invAddrQ <= regWdata;
      if (strobe.baseWr) baseQ <= {regWdata[DATA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
      if (strobe.pageOn)       pagingQ <= 1'b1;
      else if (strobe.pageOff) pagingQ <= 1'b0;
      if (faultEvt && !faultQ) begin
        faultQ     <= 1'b1;
        faultAddrQ <= faultVa;
        faultWrQ   <= faultIsWrite;
        busIdQ     <= faultBusId;
      end else if (strobe.faultAck) begin
        faultQ <= 1'b0;
      end
      rawQ <= (rawQ & ~clrVec) | evtVec;
      if (strobe.maskWr) maskQ <= regWdata[NUM_IRQ-1:0];
    end
  end

  // BASE_W kept for readers of the field width
  logic [BASE_W-1:0] baseField;
  assign baseField = baseQ[DATA_W-1:PAGE_SHIFT];
endmodule

// File: rtl/xlat_mode_ctrl.sv
module xlat_mode_ctrl
  import xlat_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        xlatBusy,
  input  logic        replayEmpty,
  input  logic        faultEvt,
  input  logic [31:0] faultVa,
  input  logic        faultIsWrite,
  input  logic [4:0]  faultBusId,
  input  logic        busErrEvt,
  output logic        pagingOn,
  output logic        stallOn,
  output logic        flushPulse,
  output logic        invPulse,
  output logic [31:0] invAddr,
  output logic [31:0] dirBase,
  output logic        irq
);
  localparam int DATA_W  = 32;
  localparam int BUSID_W = 5;
  localparam int NUM_IRQ = 2;

  ctl_strobe_t        strobe;
  logic               faultActive, faultWr;
  logic [DATA_W-1:0]  faultAddr;
  logic [BUSID_W-1:0] busId;
  logic [NUM_IRQ-1:0] rawStat, intMask, maskedStat;
  logic [DATA_W-1:0]  statusWord;

  xlat_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .cmdCode(regWdata[2:0]), .faultActive(faultActive), .xlatBusy(xlatBusy),
    .strobe(strobe), .stallOn(stallOn)
  );

  xlat_reg_bank #(.DATA_W(DATA_W), .PAGE_SHIFT(12), .BUSID_W(BUSID_W), .NUM_IRQ(NUM_IRQ)) u_bank (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWdata(regWdata),
    .faultEvt(faultEvt), .faultVa(faultVa), .faultIsWrite(faultIsWrite),
    .faultBusId(faultBusId), .busErrEvt(busErrEvt),
    .baseQ(dirBase), .pagingQ(pagingOn), .faultQ(faultActive),
    .faultAddrQ(faultAddr), .faultWrQ(faultWr), .busIdQ(busId),
    .rawQ(rawStat), .maskQ(intMask), .flushQ(flushPulse),
    .invQ(invPulse), .invAddrQ(invAddr)
  );

  always_comb begin
    maskedStat = rawStat & intMask;
    irq        = |maskedStat;
    statusWord = {~stallOn, 20'b0, busId, faultWr, replayEmpty, ~xlatBusy,
                  stallOn, faultActive, pagingOn};
    regRdata   = '0;
    case (regAddr)
      OFS_BASE:  regRdata = dirBase;
      OFS_STAT:  regRdata = statusWord;
      OFS_FADDR: regRdata = faultAddr;
      OFS_RAW:   regRdata[NUM_IRQ-1:0] = rawStat;
      OFS_MASK:  regRdata[NUM_IRQ-1:0] = intMask;
      OFS_MSTAT: regRdata[NUM_IRQ-1:0] = maskedStat;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/xlat_mode_ctrl_chk.sv
module xlat_mode_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [7:0]  regAddr,
  input logic [31:0] regWdata,
  input logic        xlatBusy,
  input logic        faultActive,
  input logic        pagingOn,
  input logic        stallOn,
  input logic        flushPulse,
  input logic        invPulse,
  input logic [31:0] invAddr
);
  logic cmdWr;
  assign cmdWr = regWe && (regAddr == 8'h08);

  // R3: a stall is only granted once drained and fault-free
  p_stall_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stallOn) |-> (!$past(faultActive) && !$past(xlatBusy)));

  // R4: a pending fault keeps stall from starting
  p_stall_refused_r4: assert property (@(posedge clk) disable iff (!rstN)
    (faultActive && !stallOn) |=> !stallOn);

  // R2: paging on follows its command
  p_paging_on_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && regWdata[2:0] == 3'd0) |=> pagingOn);

  // R6: every flush pulse comes from a flush command
  p_flush_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |-> $past(cmdWr && regWdata[2:0] == 3'd4));

  // R7: invalidate pulse carries the written address
  p_inv_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    invPulse |-> ($past(regWe && regAddr == 8'h10) && invAddr == $past(regWdata)));

  // R8: fault held until acknowledge or hard reset
  p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (faultActive && !(cmdWr && (regWdata[2:0] == 3'd5 || regWdata[2:0] == 3'd6)))
      |=> faultActive);
endmodule

bind xlat_mode_ctrl xlat_mode_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .xlatBusy(xlatBusy), .faultActive(faultActive), .pagingOn(pagingOn),
  .stallOn(stallOn), .flushPulse(flushPulse), .invPulse(invPulse), .invAddr(invAddr)
);

// File: tb/xlat_mode_ctrl_bench.sv
`timescale 1ns/1ps
module xlat_mode_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = 8'h0;
  logic [31:0] regWdata = 32'h0;
  logic [31:0] regRdata;
  logic        xlatBusy = 1'b0;
  logic        replayEmpty = 1'b1;
  logic        faultEvt = 1'b0;
  logic [31:0] faultVa = 32'h0;
  logic        faultIsWrite = 1'b0;
  logic [4:0]  faultBusId = 5'h0;
  logic        busErrEvt = 1'b0;
  logic        pagingOn, stallOn, flushPulse, invPulse, irq;
  logic [31:0] invAddr, dirBase;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  xlat_mode_ctrl u_xlat_mode_ctrl (.*);

  function automatic logic [31:0] statExp(input logic pg, input logic flt, input logic stl,
                                          input logic idle, input logic rep, input logic wr,
                                          input logic [4:0] id);
    return {~stl, 20'b0, id, wr, rep, idle, stl, flt, pg};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic pulseFault(input logic [31:0] va, input logic w, input logic [4:0] id);
    @(negedge clk);
    faultEvt = 1'b1; faultVa = va; faultIsWrite = w; faultBusId = id;
    @(negedge clk);
    faultEvt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [1:0]  rawM, maskM;
    void'($urandom(32'h1d2c3b4a));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state (R10 values)
    rdReg(8'h04, rd); chk("R10 reset status", rd, statExp(0,0,0,1,1,0,0));
    chk("R10 reset paging", {31'b0, pagingOn}, 0);
    chk("R10 reset irq", {31'b0, irq}, 0);

    // R1 base truncation
    wrReg(8'h00, 32'hCAFEBABE);
    rdReg(8'h00, rd); chk("R1 base readback", rd, 32'hCAFEB000);
    chk("R1 dirBase port", dirBase, 32'hCAFEB000);

    // R2 paging
    wrReg(8'h08, 32'd0);
    chk("R2 paging on", {31'b0, pagingOn}, 1);
    rdReg(8'h04, rd); chk("R2 status bit0 on", {31'b0, rd[0]}, 1);
    wrReg(8'h08, 32'd1);
    chk("R2 paging off", {31'b0, pagingOn}, 0);
    wrReg(8'h08, 32'd0);

    // R6 flush pulse
    wrReg(8'h08, 32'd4);
    chk("R6 flush high", {31'b0, flushPulse}, 1);
    @(negedge clk);
    chk("R6 flush one cycle", {31'b0, flushPulse}, 0);

    // R7 invalidate
    wrReg(8'h10, 32'h1234_5000);
    chk("R7 inv pulse", {31'b0, invPulse}, 1);
    chk("R7 inv addr", invAddr, 32'h1234_5000);
    @(negedge clk);
    chk("R7 inv one cycle", {31'b0, invPulse}, 0);

    // R3 stall waits for drain
    xlatBusy = 1'b1;
    wrReg(8'h08, 32'd2);
    repeat (3) @(negedge clk);
    chk("R3 stall waits busy", {31'b0, stallOn}, 0);
    rdReg(8'h04, rd); chk("R3 status busy", rd, statExp(1,0,0,0,1,0,0));
    xlatBusy = 1'b0;
    @(negedge clk);
    chk("R3 stall after drain", {31'b0, stallOn}, 1);
    replayEmpty = 1'b0;
    rdReg(8'h04, rd); chk("R3 status stalled", rd, statExp(1,0,1,1,0,0,0));
    replayEmpty = 1'b1;

    // R5 leave stall
    wrReg(8'h08, 32'd3);
    chk("R5 stall off", {31'b0, stallOn}, 0);
    rdReg(8'h04, rd); chk("R5 status bit31", {31'b0, rd[31]}, 1);

    // R8 fault capture, first one held
    pulseFault(32'hDEAD_1234, 1'b1, 5'h13);
    pulseFault(32'h1111_2222, 1'b0, 5'h02);
    rdReg(8'h0C, rd); chk("R8 fault addr held", rd, 32'hDEAD_1234);
    rdReg(8'h04, rd); chk("R8 fault status", rd, statExp(1,1,0,1,1,1,5'h13));
    rdReg(8'h14, rd); chk("R8 raw bit0", rd, 32'h1);

    // R4 stall refused during fault
    wrReg(8'h08, 32'd2);
    @(negedge clk);
    chk("R4 stall refused", {31'b0, stallOn}, 0);
    wrReg(8'h08, 32'd5);
    rdReg(8'h04, rd); chk("R8 ack clears fault", {31'b0, rd[1]}, 0);
    @(negedge clk);
    chk("R4 no stall after ack", {31'b0, stallOn}, 0);

    // R9 mask / clear directed
    rdReg(8'h20, rd); chk("R9 masked zero", rd, 0);
    chk("R9 irq off", {31'b0, irq}, 0);
    wrReg(8'h1C, 32'h3);
    rdReg(8'h20, rd); chk("R9 masked fault", rd, 32'h1);
    chk("R9 irq on", {31'b0, irq}, 1);
    wrReg(8'h18, 32'h1);
    rdReg(8'h14, rd); chk("R9 cleared", rd, 0);
    // event and clear together: event wins
    @(negedge clk);
    regWe = 1'b1; regAddr = 8'h18; regWdata = 32'h2; busErrEvt = 1'b1;
    @(negedge clk);
    regWe = 1'b0; busErrEvt = 1'b0;
    rdReg(8'h14, rd); chk("R9 event beats clear", rd, 32'h2);

    // R9 random traffic on raw and mask
    rawM = 2'b10; maskM = 2'b11;
    for (int i = 0; i < 300; i++) begin
      logic [1:0] ev, d;
      int sel;
      ev = 2'($urandom); d = 2'($urandom); sel = int'($urandom_range(0, 2));
      @(negedge clk);
      faultEvt = ev[0]; busErrEvt = ev[1];
      regWe = (sel != 0); regAddr = (sel == 1) ? 8'h18 : 8'h1C; regWdata = {30'b0, d};
      @(negedge clk);
      faultEvt = 1'b0; busErrEvt = 1'b0; regWe = 1'b0;
      rawM = (rawM & ~((sel == 1) ? d : 2'b00)) | ev;
      if (sel == 2) maskM = d;
      rdReg(8'h14, rd); chk("R9 random raw", rd, {30'b0, rawM});
      rdReg(8'h20, rd); chk("R9 random masked", rd, {30'b0, rawM & maskM});
      chk("R9 random irq", {31'b0, irq}, {31'b0, |(rawM & maskM)});
    end

    // R10 hard reset
    wrReg(8'h00, 32'h8765_4321);
    wrReg(8'h08, 32'd0);
    wrReg(8'h08, 32'd2);
    wrReg(8'h08, 32'd6);
    rdReg(8'h00, rd); chk("R10 base zero", rd, 0);
    rdReg(8'h14, rd); chk("R10 raw zero", rd, 0);
    rdReg(8'h1C, rd); chk("R10 mask zero", rd, 0);
    rdReg(8'h04, rd); chk("R10 status power-on", rd, statExp(0,0,0,1,1,0,0));
    chk("R10 outputs off", {29'b0, pagingOn, stallOn, irq}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule